// File: doc/BRIEF.md
# Integer ALU with Condition and Control Flag Word

This block is a 16-bit arithmetic/logic unit with an 8-bit mode, paired with a 16-bit flag word. Each cycle it takes two operands, an operation code and a width select, and produces a combinational result together with a write-back qualifier. At the next rising clock edge, if the flag-write enable is high, the flag word takes the condition flags derived from that result.

The arithmetic operations are add, add with carry, subtract, subtract with borrow and compare. The logic operations are AND, OR and XOR. Add with carry and subtract with borrow take their carry-in from the stored carry flag. Three control flags are kept in the same word: trap, interrupt enable and direction. Only two dedicated set and clear commands change them, and arithmetic results never do.

The condition flags sit at fixed bit positions, because other logic decodes the word by position. Bits that carry no flag always read as zero.

Top module: `alu_flagreg`

## Requirements
- R1: Opcode 0 (add) gives A+B and opcode 1 (add with carry) gives A+B+CF. The result is truncated to the selected width. CF (flag bit 0) is set to the carry out of the most significant bit of that width.
- R2: Opcode 2 (subtract) gives A-B and opcode 3 (subtract with borrow) gives A-B-CF, wrapped to the width. CF is set when a borrow out of the most significant bit occurred.
- R3: For add operations, OF (bit 11) is set when the two operands have the same sign and the result sign differs from it. For subtract and compare, OF is set when the operand signs differ and the result sign differs from the sign of A.
- R4: After any arithmetic or logic operation, each of these flags is written:
  - ZF (bit 6) is set when the width-limited result is zero.
  - SF (bit 7) is the result's most significant bit.
  - PF (bit 2) is set when the low 8 result bits contain an even number of ones.
  - AF (bit 4) is set after an add or subtract when there was a carry or borrow out of bit 3.
- R5: Opcodes 5, 6 and 7 give A AND B, A OR B and A XOR B. They clear CF and OF, leave AF unchanged, and update PF, ZF and SF.
- R6: When byte mode is high, only the low 8 operand bits are used and result bits 15:8 are zero. Bit 7 then acts as the most significant bit for CF, OF and SF.
- R7: Opcode 4 (compare) writes the same flags as subtract. Its result_valid output is 0. Opcodes 0 to 3 and 5 to 7 drive result_valid to 1.
- R8: Opcode 8 sets, and opcode 9 clears, the control flags selected by B bit 0 (TF, bit 8), B bit 1 (IF, bit 9) and B bit 2 (DF, bit 10). Opcodes 0 to 7 never change bits 8 to 10. Opcodes 8 and 9 leave the condition flags unchanged and give result 0 with result_valid 0.
- R9: The flag word changes only on a rising clock edge with flag_we high; otherwise it holds. An active-low reset clears the whole word.
- R10: Bits 1, 3, 5 and 12 to 15 of the flag word always read 0. Opcodes 10 to 15 give result 0 and result_valid 0, and leave the flag word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag word |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B; bits 2:0 select control flags for opcodes 8 and 9 |
| opcode | input | 4 | Operation select (see requirements) |
| byte_mode | input | 1 | 1 selects 8-bit width |
| flag_we | input | 1 | Enables the flag-word update at the next edge |
| result | output | 16 | Combinational result |
| result_valid | output | 1 | 1 when the result is meant to be written back |
| flags | output | 16 | Registered flag word |

## Verification
A wrong carry, borrow or overflow computation shows directly on the flag word one edge after the offending operation. A corrupted carry flag also appears in the result of the next add-with-carry or subtract-with-borrow. Control bits that drift, or undefined bits that become set, are visible on the flag word at every later edge until a command rewrites them. For these reasons the bench compares the result before each edge and the whole flag word after it, so any divergence is reported within the same cycle.

// File: rtl/alu_flagreg.sv
module alu_flagreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   opcode,
  input  logic         byte_mode,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         result_valid,
  output logic [15:0]  flags
);
  localparam int HB = W / 2;
  localparam logic [15:0] DEF_MASK = 16'h0FD5;

  localparam int B_CF = 0;
  localparam int B_PF = 2;
  localparam int B_AF = 4;
  localparam int B_ZF = 6;
  localparam int B_SF = 7;
  localparam int B_TF = 8;
  localparam int B_OF = 11;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_SETC = 4'd8, OP_CLRC = 4'd9
  } op_t;

  logic [15:0] flg_q, flg_d;

  logic [W-1:0] am, bm;
  assign am = byte_mode ? {{HB{1'b0}}, op_a[HB-1:0]} : op_a;
  assign bm = byte_mode ? {{HB{1'b0}}, op_b[HB-1:0]} : op_b;

  logic cin;
  assign cin = (opcode == OP_ADC || opcode == OP_SBB) ? flg_q[B_CF] : 1'b0;

  logic [W:0] sum, dif, raw;
  assign sum = {1'b0, am} + {1'b0, bm} + {{W{1'b0}}, cin};
  assign dif = {1'b0, am} - {1'b0, bm} - {{W{1'b0}}, cin};

  logic is_add, is_sub, is_log;
  assign is_add = (opcode == OP_ADD) || (opcode == OP_ADC);
  assign is_sub = (opcode == OP_SUB) || (opcode == OP_SBB) || (opcode == OP_CMP);
  assign is_log = (opcode == OP_AND) || (opcode == OP_OR) || (opcode == OP_XOR);

  always_comb begin
    case (opcode)
      OP_AND:  raw = {1'b0, am & bm};
      OP_OR:   raw = {1'b0, am | bm};
      OP_XOR:  raw = {1'b0, am ^ bm};
      default: raw = is_add ? sum : dif;
    endcase
  end

  logic [W-1:0] res;
  assign res = byte_mode ? {{HB{1'b0}}, raw[HB-1:0]} : raw[W-1:0];

  logic carry, r_msb, a_msb, b_msb, ovf, aux;
  assign carry = byte_mode ? raw[HB] : raw[W];
  assign r_msb = byte_mode ? res[HB-1] : res[W-1];
  assign a_msb = byte_mode ? am[HB-1] : am[W-1];
  assign b_msb = byte_mode ? bm[HB-1] : bm[W-1];
  assign aux   = am[4] ^ bm[4] ^ raw[4];
  assign ovf   = is_add ? (a_msb == b_msb) && (r_msb != a_msb)
                        : (a_msb != b_msb) && (r_msb != a_msb);

  assign result       = (is_add || is_sub || is_log) && opcode != OP_CMP ? res
                      : (opcode == OP_CMP ? res : '0);
  assign result_valid = is_add || is_log || (is_sub && opcode != OP_CMP);

  always_comb begin
    flg_d = flg_q;
    if (is_add || is_sub || is_log) begin
      flg_d[B_ZF] = (res == '0);
      flg_d[B_SF] = r_msb;
      flg_d[B_PF] = ~^res[7:0];
      flg_d[B_CF] = is_log ? 1'b0 : carry;
      flg_d[B_OF] = is_log ? 1'b0 : ovf;
      if (!is_log) flg_d[B_AF] = aux;
    end else if (opcode == OP_SETC) begin
      flg_d[B_TF +: 3] = flg_q[B_TF +: 3] | op_b[2:0];
    end else if (opcode == OP_CLRC) begin
      flg_d[B_TF +: 3] = flg_q[B_TF +: 3] & ~op_b[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flg_q <= '0;
    else if (flag_we) flg_q <= flg_d & DEF_MASK;
  end

  assign flags = flg_q;

  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~DEF_MASK) == 16'h0);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));
  a_r8_ctl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode < 4'd8) |=> $stable(flags[10:8]));
  a_r5_logic_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_log) |=> (!flags[B_CF] && !flags[B_OF]));
  a_r5_af_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_log) |=> $stable(flags[B_AF]));
  a_r7_cmp_nowb: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_CMP) |-> !result_valid);
  a_r6_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (result[W-1:HB] == '0));
endmodule

// File: tb/tb_alu_flagreg.sv
module tb_alu_flagreg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] op_a = 0, op_b = 0;
  logic [3:0]  opcode = 0;
  logic        byte_mode = 0, flag_we = 0;
  logic [15:0] result, flags;
  logic        result_valid;

  int checks = 0, fails = 0;
  logic [15:0] mflags = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_flagreg dut (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .byte_mode(byte_mode), .flag_we(flag_we),
    .result(result), .result_valid(result_valid), .flags(flags));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] a, b, input int op, input bit bm,
                       input logic [15:0] fin, output int r, output bit v,
                       output logic [15:0] fo);
    int half, mask, ua, ub, ci, t, sa, sb, s, lo;
    bit cf, of, af;
    half = bm ? 128 : 32768;
    mask = 2 * half - 1;
    ua = int'(a) & mask; ub = int'(b) & mask;
    sa = (ua >= half) ? ua - 2 * half : ua;
    sb = (ub >= half) ? ub - 2 * half : ub;
    fo = fin; r = 0; v = 0;
    ci = (op == 1 || op == 3) ? int'(fin[0]) : 0;
    if (op <= 1) begin
      t = ua + ub + ci; r = t & mask; cf = t > mask;
      af = ((ua & 15) + (ub & 15) + ci) > 15;
      s = sa + sb + ci; of = (s > half - 1) || (s < -half);
    end else if (op <= 4) begin
      t = ua - ub - ci; r = t & mask; cf = t < 0;
      af = ((ua & 15) - (ub & 15) - ci) < 0;
      s = sa - sb - ci; of = (s > half - 1) || (s < -half);
    end else if (op <= 7) begin
      r = (op == 5) ? (ua & ub) : (op == 6) ? (ua | ub) : (ua ^ ub);
      cf = 0; of = 0; af = fin[4];
    end
    if (op <= 7) begin
      v = (op != 4);
      lo = r & 255;
      fo[0] = cf; fo[11] = of; fo[4] = af;
      fo[6] = (r == 0);
      fo[7] = (r >= half);
      fo[2] = ($countones(lo[7:0]) % 2) == 0;
    end else if (op == 8) fo[10:8] = fin[10:8] | b[2:0];
    else if (op == 9) fo[10:8] = fin[10:8] & ~b[2:0];
    if (op > 7) r = 0;
  endtask

  task automatic step(input logic [15:0] a, b, input int op, input bit bm,
                      input bit we, input string tag);
    int er; bit ev; logic [15:0] ef;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op[3:0]; byte_mode = bm; flag_we = we;
    #2;
    model(a, b, op, bm, mflags, er, ev, ef);
    check({tag, " result"}, int'(result), er);
    check({tag, " result_valid"}, int'(result_valid), int'(ev));
    @(posedge clk); #1;
    if (we) mflags = ef;
    check({tag, " flags"}, int'(flags), int'(mflags));
  endtask

  initial begin
    #2;
    check("R9 reset flags", int'(flags), 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step(16'hFFFF, 16'h0001, 0, 0, 1, "R1 add carry-out zero R4");
    step(16'h1234, 16'h0001, 1, 0, 1, "R1 adc with CF");
    step(16'h7FFF, 16'h0001, 0, 0, 1, "R3 add overflow R4 AF");
    step(16'h8000, 16'h0001, 2, 0, 1, "R3 sub overflow");
    step(16'h0000, 16'h0001, 2, 0, 1, "R2 sub borrow");
    step(16'h0010, 16'h0005, 3, 0, 1, "R2 sbb with CF");
    step(16'h0005, 16'h0005, 4, 0, 1, "R7 cmp equal");
    step(16'h0003, 16'h0009, 4, 1, 1, "R7 cmp byte borrow");
    step(16'hAB7F, 16'hCD01, 0, 1, 1, "R6 byte overflow");
    step(16'h12FF, 16'h3401, 0, 1, 1, "R6 byte carry");
    step(16'hF0F0, 16'h0F0F, 6, 0, 1, "R5 or clears CF OF AF kept");
    step(16'hFFFF, 16'h00FF, 5, 0, 1, "R5 and");
    step(16'h00FF, 16'h00FF, 7, 0, 1, "R5 xor zero");
    step(16'h0000, 16'h0007, 8, 0, 1, "R8 set all control");
    step(16'hFFFF, 16'h0001, 0, 0, 1, "R8 arith keeps control");
    step(16'h0000, 16'h0002, 9, 0, 1, "R8 clear IF");
    step(16'h0001, 16'h0001, 2, 0, 0, "R9 hold without we");
    step(16'hFFFF, 16'hFFFF, 12, 0, 1, "R10 undefined opcode");
    step(16'hFFFF, 16'hFFFF, 15, 1, 1, "R10 undefined opcode byte");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      int sel;
      a = 16'($urandom); b = 16'($urandom);
      sel = $urandom_range(0, 7);
      if (sel == 0) a = 16'h7FFF; else if (sel == 1) b = 16'hFFFF;
      else if (sel == 2) a = 16'h0080;
      step(a, b, $urandom_range(0, 15), 1'($urandom), $urandom_range(0, 7) != 0,
           "R1 R2 R3 R4 R6 R8 R10 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule